// File: doc/BRIEF.md
# I2C Configuration Register Slave

This block is a two-wire serial slave that lets a host processor read and write a bank of sixteen 8-bit configuration registers. The clock and data lines are oversampled by a system clock at least sixteen times faster than the serial clock. START, repeated START and STOP conditions are recovered from that oversampled view. Only a fixed 7-bit device address is answered.

A write transfer sends the device address, one pointer byte and then any number of data bytes. The pointer advances after every byte and wraps from the last register back to register 0. A read transfer returns bytes from the current pointer onward. The host can set the pointer first in a write phase and then switch direction with a repeated START. It can also skip the pointer phase and resume after the last register it touched.

The data line is controlled open-drain: the block either pulls it low or lets it go. All register contents are presented in parallel to the surrounding logic.

Top module: `i2c_cfg_slave`

## Requirements
- R1: After rst_n is low, every register i holds the reset value ((i*29) mod 256) XOR A5h, the data line is released, and the block waits for a START.
- R2: A first byte whose upper seven bits are 1110110 is acknowledged by pulling SDA low during the ninth clock; its LSB selects the direction (0 = write, 1 = read).
- R3: A first byte with any other address gets no acknowledge, SDA stays released until the next START, and no register changes.
- R4: The block changes its SDA drive only while SCL is low, and it acknowledges every pointer byte and every written data byte.
- R5: In a write, the byte after the address sets the pointer (its low 4 bits select the register, the upper bits are ignored); each later byte is stored at the pointer, which then advances by one.
- R6: Advancing from register 15 sets the pointer to register 0, both in writes and in reads.
- R7: A read whose first byte is the read address returns data starting at the register after the last one written or read.
- R8: A write phase that only sets the pointer, followed by a repeated START with a read address, returns data from that pointer with no STOP in between.
- R9: Read bytes go out MSB first; a host acknowledge makes the block send the next register, and a host not-acknowledge ends the read with SDA released.
- R10: A START or STOP that arrives before a data byte completes abandons it: no register is written and a START returns to address matching.
- R11: regs_o carries register i on bits [8i+7:8i] and changes only when a written data byte completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release |
| regs_o | output | 128 | All register contents, register i at [8i+7:8i] |

## Verification
The pointer wrap and the store of a data byte happen in the same system-clock cycle when a write reaches register 15: the byte must land in register 15 while the pointer moves to 0. The bench provokes this with directed bursts that start at registers 14 and 15 and with random bursts whose start and length are drawn freely. It judges the outcome on regs_o and by a following read without a pointer phase, which must begin at register 0 or later as predicted by its own model.

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'b1110110,
  parameter int NREG = 16,
  localparam int AW = $clog2(NREG),
  localparam int RW = NREG * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [RW-1:0] regs_o
);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_PTR, S_PACK, S_WDATA, S_WACK, S_RDATA, S_RACK
  } st_t;

  localparam logic [AW-1:0] LAST = AW'(NREG - 1);

  function automatic logic [7:0] rstval(int i);
    return 8'(i * 29) ^ 8'hA5;
  endfunction

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic [2:0] scl_q, sda_q;
  st_t        state;
  logic [3:0] cnt;
  logic [7:0] shreg, txbyte;
  logic [AW-1:0] ptr;
  logic       nack;
  logic [7:0] regs [NREG];

  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire scl_hi   = scl_q[1] & scl_q[2];
  wire start_c  = scl_hi & sda_q[2] & ~sda_q[1];
  wire stop_c   = scl_hi & ~sda_q[2] & sda_q[1];
  wire sda_s    = sda_q[1];
  wire rx_state = (state == S_ADDR) | (state == S_PTR) | (state == S_WDATA);

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*8 +: 8] = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      txbyte <= '0;
      ptr    <= '0;
      nack   <= 1'b0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= rstval(i);
    end else if (start_c) begin
      state  <= S_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else if (rx_state) begin
      if (scl_rise && cnt < 4'd8) begin
        shreg <= {shreg[6:0], sda_s};
        cnt   <= cnt + 1'b1;
      end else if (scl_fall && cnt == 4'd8) begin
        cnt <= '0;
        case (state)
          S_ADDR: begin
            if (shreg[7:1] == DEV_ADDR) begin
              sda_oe <= 1'b1;
              nack   <= shreg[0];
              state  <= S_AACK;
            end else begin
              state <= S_IDLE;
            end
          end
          S_PTR: begin
            ptr    <= shreg[AW-1:0];
            sda_oe <= 1'b1;
            state  <= S_PACK;
          end
          default: begin
            regs[ptr] <= shreg;
            ptr       <= nxt(ptr);
            sda_oe    <= 1'b1;
            state     <= S_WACK;
          end
        endcase
      end
    end else begin
      case (state)
        S_AACK, S_PACK, S_WACK: if (scl_fall) begin
          cnt <= '0;
          if (state == S_AACK && nack) begin
            txbyte <= regs[ptr];
            sda_oe <= ~regs[ptr][7];
            state  <= S_RDATA;
          end else begin
            sda_oe <= 1'b0;
            state  <= (state == S_AACK) ? S_PTR : S_WDATA;
          end
        end
        S_RDATA: if (scl_fall) begin
          if (cnt == 4'd7) begin
            sda_oe <= 1'b0;
            ptr    <= nxt(ptr);
            state  <= S_RACK;
          end else begin
            txbyte <= {txbyte[6:0], 1'b0};
            sda_oe <= ~txbyte[6];
            cnt    <= cnt + 1'b1;
          end
        end
        S_RACK: begin
          if (scl_rise) nack <= sda_s;
          else if (scl_fall) begin
            if (nack) begin
              state <= S_IDLE;
            end else begin
              txbyte <= regs[ptr];
              sda_oe <= ~regs[ptr][7];
              cnt    <= '0;
              state  <= S_RDATA;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R4: drive changes only while the synchronized clock is low
  p_drive_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_q[1]);

  // R3: an unmatched address leaves the line released
  p_no_ack_foreign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_ADDR && state == S_IDLE) |-> !sda_oe);

  // R2: entering the address acknowledge means the matched address was received
  p_ack_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_ADDR && state == S_AACK) |-> ($past(shreg[7:1]) == DEV_ADDR && sda_oe));

  // R6: advancing from the last register goes to 0
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(state) == S_WDATA || $past(state) == S_RDATA) && $past(ptr) == LAST && ptr != LAST)
      |-> ptr == '0);

  // R11: register outputs change only when a written byte completes
  p_regs_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_o != $past(regs_o)) |-> ($past(state) == S_WDATA && state == S_WACK));

  // R9: transmit drive holds between clock falls
  p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_RDATA && state == S_RDATA && !$past(scl_fall)) |-> $stable(sda_oe));

endmodule

// File: tb/i2c_cfg_slave_tb.sv
module i2c_cfg_slave_tb_top;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'b1110110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [127:0] regs_o;
  wire sda_bus = sda_m & ~sda_oe;

  i2c_cfg_slave dut_i (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
                       .sda_oe(sda_oe), .regs_o(regs_o));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  bit watch_quiet = 0, quiet_bad = 0;
  logic [7:0] mem [16];
  logic [3:0] mptr = 0;

  always @(posedge clk) if (watch_quiet && sda_oe) quiet_bad = 1;

  function automatic logic [7:0] rv(int i);
    return 8'(i * 29) ^ 8'hA5;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(int n); repeat (n) @(negedge clk); endtask

  task automatic start_c;
    sda_m = 1; w(Q); scl = 1; w(Q); sda_m = 0; w(Q); scl = 0; w(Q);
  endtask

  task automatic stop_c;
    sda_m = 0; w(Q); scl = 1; w(Q); sda_m = 1; w(2*Q);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; w(Q); scl = 1; w(Q); s = sda_bus; w(Q); scl = 0; w(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, ack);
  endtask

  task automatic rd_byte(input logic host_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); d[i] = s; end
    clk_bit(host_ack, s);
    sda_m = 1;
  endtask

  function automatic logic [7:0] mregs(int i);
    return regs_o[i*8 +: 8];
  endfunction

  task automatic chk_regs(string req);
    for (int i = 0; i < 16; i++) chk(req, mregs(i), mem[i]);
  endtask

  task automatic do_write(logic [7:0] p, int n, logic [7:0] seed);
    logic a;
    start_c;
    wr_byte({DEV, 1'b0}, a); chk("R2 write addr ack", a, 0);
    wr_byte(p, a); chk("R4 ptr ack", a, 0);
    mptr = p[3:0];
    for (int k = 0; k < n; k++) begin
      logic [7:0] d = seed + 8'(k * 37);
      wr_byte(d, a); chk("R4 data ack", a, 0);
      mem[mptr] = d; mptr = mptr + 1;
    end
    stop_c;
  endtask

  task automatic read_bytes(string req, int n);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      rd_byte(k == n - 1, d);
      chk(req, d, mem[mptr]); mptr = mptr + 1;
    end
  endtask

  task automatic do_cur_read(int n);
    logic a;
    start_c;
    wr_byte({DEV, 1'b1}, a); chk("R2 read addr ack", a, 0);
    read_bytes("R7 current read", n);
    chk("R9 released after nack", sda_oe, 0);
    stop_c;
  endtask

  task automatic do_comb_read(logic [7:0] p, int n);
    logic a;
    start_c;
    wr_byte({DEV, 1'b0}, a); chk("R2 addr ack", a, 0);
    wr_byte(p, a); chk("R4 ptr ack", a, 0);
    mptr = p[3:0];
    start_c;
    wr_byte({DEV, 1'b1}, a); chk("R8 read addr ack", a, 0);
    read_bytes("R8 combined read", n);
    stop_c;
  endtask

  initial begin : main
    logic a;
    logic [7:0] d;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 16; i++) mem[i] = rv(i);
    w(5); rst_n = 1; w(5);
    chk("R1 sda released", sda_oe, 0);
    chk_regs("R1 reset value");

    // R3: foreign address
    watch_quiet = 1;
    start_c; wr_byte({7'b1110111, 1'b0}, a); chk("R3 no ack", a, 1);
    wr_byte(8'h02, a); wr_byte(8'h5A, a); stop_c;
    start_c; wr_byte({7'b0110110, 1'b1}, a); chk("R3 no ack read", a, 1);
    stop_c;
    watch_quiet = 0;
    chk("R3 line untouched", quiet_bad, 0);
    chk_regs("R3 regs unchanged");

    // R5 R6: burst across the last register, upper pointer bits ignored
    do_write(8'hFE, 4, 8'h31);
    chk_regs("R6 wrap write");
    chk("R11 reg15 lane", mregs(15), mem[15]);
    do_cur_read(2);                 // R7 resumes at register 2
    do_write(8'h03, 1, 8'hC4);
    chk("R5 single write", mregs(3), 8'hC4);
    do_cur_read(1);                 // R7 next after written reg 3

    // R8 R9 R6: combined read wrapping with host acks
    do_comb_read(8'h0E, 4);
    do_comb_read(8'h0F, 1);
    do_cur_read(1);                 // R6 read wrap left pointer at 0

    // R10: START in the middle of a data byte
    start_c; wr_byte({DEV, 1'b0}, a); wr_byte(8'h05, a);
    mptr = 5;
    for (int i = 0; i < 4; i++) begin logic s; clk_bit(1'b0, s); end
    start_c;
    wr_byte({DEV, 1'b1}, a); chk("R10 restart ack", a, 0);
    rd_byte(1'b1, d); chk("R10 aborted byte not stored", d, mem[5]);
    mptr = 6;
    stop_c;
    // R10: STOP in the middle of a data byte
    start_c; wr_byte({DEV, 1'b0}, a); wr_byte(8'h08, a);
    mptr = 8;
    begin logic s; clk_bit(1'b1, s); clk_bit(1'b0, s); end
    stop_c;
    chk_regs("R10 stop abort");
    do_cur_read(1);

    // random mix
    for (int it = 0; it < 30; it++) begin
      int op = $urandom_range(0, 2);
      int n = $urandom_range(1, 5);
      logic [7:0] p = 8'($urandom);
      if (op == 0) begin do_write(p, n, 8'($urandom)); chk_regs("R11 random write"); end
      else if (op == 1) do_comb_read(p, n);
      else do_cur_read(n);
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule